// File: doc/BRIEF.md
# Periodic Interval Timer with Live Countdown

This block raises a periodic interrupt at a programmable interval and exposes its down-counter as a fine-resolution time base. The counter runs from one below the programmed period down to zero, then reloads, for as long as the period is nonzero. It moves only on cycles where `tick_en` is high, so the pulse rate on that input sets the time unit (the granularity). Every expiry sets an interrupt flag. The flag stays high until software clears it.

Software uses a small synchronous register port: a write strobe, a read strobe, an address and data buses. The period register reads back the period that the hardware is actually running, not the last value written. The count register gives the whole granularity ticks left before the next interrupt. A constant register reports the largest period the block accepts. Writing zero halts the timer at once. A new nonzero period written while the timer runs is held until the running interval finishes.

Register map (3-bit address): 0 = period (write: request, read: active period); 1 = countdown (read only); 2 = interrupt (write bit 0 = 1 clears, read bit 0 = flag); 3 = maximum period (read only). Any other address reads zero and ignores writes.

Top module: `ptmr_top`

## Requirements
- R1: After reset the timer is stopped: the period reads 0, the countdown reads 0 and `irq` is low.
- R2: With a nonzero active period P, each cycle with `tick_en` high decrements the countdown by one. A tick at countdown 0 reloads it with P-1, so the countdown always stays below P.
- R3: On a cycle where `tick_en` is low and no period is written, the countdown holds its value.
- R4: A tick taken at countdown 0 with a nonzero period (an expiry) sets `irq` in the next cycle. `irq` then stays high until it is cleared.
- R5: Writing address 2 with bit 0 = 1 clears `irq`. Writing it with bit 0 = 0 has no effect. If an expiry happens in the same cycle as a clear, `irq` stays set.
- R6: Writing 0 to address 0 stops the timer at once. The active period and the countdown both become 0, any held period is discarded, and no further expiry occurs.
- R7: Writing a nonzero period V while the timer is stopped starts it immediately. The period reads V and the countdown reads V-1.
- R8: Writing a nonzero period while the timer runs does not change the active period. The new value is loaded at the next expiry, with the countdown at V-1. Until then, reading address 0 returns the old period.
- R9: A period write above 2^WIDTH is clamped to 2^WIDTH. The active period never exceeds 2^WIDTH.
- R10: Address 3 reads the constant 2^WIDTH.
- R11: Read data appears on `rd_data` in the cycle after `rd_en` and reflects the state before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Granularity tick; counter advances when high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | DW (32) | Write data |
| rd_data | output | DW (32) | Registered read data |
| irq | output | 1 | Latched expiry interrupt |

## Verification
The assertions assume that the counter state changes only through a tick or a period write. A clear write must therefore not be able to disturb the countdown, and the inputs must settle between clock edges. The bench drives every input on the falling edge, so a tick, a write and a read are each seen whole at one rising edge. It also lines up clear writes with expiries by running a one-tick period with the tick held high, so the clear-against-set priority is actually exercised. Period writes cover zero, small values, values above the limit and the limit itself, so the clamp stays within the documented range.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int PTMR_AW = 3;

    typedef enum logic [PTMR_AW-1:0] {
        REG_PERIOD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_IRQ    = 3'd2,
        REG_LIMIT  = 3'd3
    } ptmr_reg_e;

endpackage

// File: rtl/ptmr_regif.sv
module ptmr_regif
    import ptmr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [PTMR_AW-1:0] addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [WIDTH:0]     per_act,
    input  logic [WIDTH-1:0]   cnt_cur,
    input  logic               irq_cur,
    output logic               per_wr,
    output logic [WIDTH:0]     per_wr_val,
    output logic               clr_req,
    output logic [DW-1:0]      rd_data
);

    localparam logic [DW-1:0]  LIMIT_DW = DW'(1) << WIDTH;
    localparam logic [WIDTH:0] LIMIT_PW = (WIDTH+1)'(1) << WIDTH;

    typedef struct packed {
        logic [DW-1:0] rd;
    } regif_s;

    regif_s s_d, s_q;

    // write decode and clamp
    always_comb begin
        per_wr  = wr_en && (addr == REG_PERIOD);
        clr_req = wr_en && (addr == REG_IRQ) && wr_data[0];
        if (wr_data > LIMIT_DW) begin
            per_wr_val = LIMIT_PW;
        end else begin
            per_wr_val = wr_data[WIDTH:0];
        end
    end

    // read mux, registered
    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            case (addr)
                REG_PERIOD: s_d.rd = DW'(per_act);
                REG_COUNT:  s_d.rd = DW'(cnt_cur);
                REG_IRQ:    s_d.rd = DW'(irq_cur);
                REG_LIMIT:  s_d.rd = LIMIT_DW;
                default:    s_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd;

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             per_wr,
    input  logic [WIDTH:0]   per_wr_val,
    output logic [WIDTH:0]   per_q,
    output logic [WIDTH-1:0] cnt_q,
    output logic             expire
);

    typedef struct packed {
        logic [WIDTH:0]   per;
        logic [WIDTH:0]   pend;
        logic             pend_v;
        logic [WIDTH-1:0] cnt;
    } cnt_s;

    cnt_s s_d, s_q;
    logic running;

    always_comb begin
        s_d     = s_q;
        running = (s_q.per != '0);
        expire  = tick_en && running && (s_q.cnt == '0);

        // interval progress
        if (expire) begin
            if (s_q.pend_v) begin
                s_d.per    = s_q.pend;
                s_d.cnt    = WIDTH'(s_q.pend - 1'b1);
                s_d.pend_v = 1'b0;
            end else begin
                s_d.cnt = WIDTH'(s_q.per - 1'b1);
            end
        end else if (tick_en && running) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end

        // software period request
        if (per_wr) begin
            if (per_wr_val == '0) begin
                s_d.per    = '0;
                s_d.cnt    = '0;
                s_d.pend   = '0;
                s_d.pend_v = 1'b0;
            end else if (!running) begin
                s_d.per    = per_wr_val;
                s_d.cnt    = WIDTH'(per_wr_val - 1'b1);
                s_d.pend_v = 1'b0;
            end else begin
                s_d.pend   = per_wr_val;
                s_d.pend_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign per_q = s_q.per;
    assign cnt_q = s_q.cnt;

endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } irq_s;

    irq_s s_d, s_q;

    // set wins over clear
    always_comb begin
        s_d = s_q;
        if (clr_req) begin
            s_d.flag = 1'b0;
        end
        if (expire) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.flag;

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [PTMR_AW-1:0] addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    output logic               irq
);

    logic             per_wr;
    logic [WIDTH:0]   per_wr_val;
    logic             clr_req;
    logic [WIDTH:0]   per_q;
    logic [WIDTH-1:0] cnt_q;
    logic             expire;

    ptmr_regif #(.WIDTH(WIDTH), .DW(DW)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .per_act    (per_q),
        .cnt_cur    (cnt_q),
        .irq_cur    (irq),
        .per_wr     (per_wr),
        .per_wr_val (per_wr_val),
        .clr_req    (clr_req),
        .rd_data    (rd_data)
    );

    ptmr_counter #(.WIDTH(WIDTH)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .per_wr     (per_wr),
        .per_wr_val (per_wr_val),
        .per_q      (per_q),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    ptmr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .clr_req (clr_req),
        .irq     (irq)
    );

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DW    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               wr_en,
    input logic [PTMR_AW-1:0] addr,
    input logic [DW-1:0]      wr_data,
    input logic [WIDTH:0]     per_q,
    input logic [WIDTH-1:0]   cnt_q,
    input logic               expire,
    input logic               irq
);

    localparam logic [WIDTH:0] LIMIT_PW = (WIDTH+1)'(1) << WIDTH;

    logic clr_w;
    logic zero_w;
    assign clr_w  = wr_en && (addr == REG_IRQ) && wr_data[0];
    assign zero_w = wr_en && (addr == REG_PERIOD) && (wr_data == '0);

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != '0) |-> ({1'b0, cnt_q} < per_q)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(cnt_q)); // R3

    AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire)); // R4

    AST_IRQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !expire) |=> !irq); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq); // R5

    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        zero_w |=> (per_q == '0 && cnt_q == '0)); // R6

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0) |-> !expire); // R6

    AST_PERIOD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        per_q <= LIMIT_PW); // R9

endmodule

bind ptmr_top ptmr_chk #(.WIDTH(WIDTH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .per_q   (per_q),
    .cnt_q   (cnt_q),
    .expire  (expire),
    .irq     (irq)
);

// File: tb/ptmr_top_bench.sv
`timescale 1ns/1ps
module ptmr_top_bench;

    localparam int WIDTH = 16;
    localparam int DW    = 32;
    localparam longint MAXP = longint'(1) << WIDTH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    ptmr_top #(.WIDTH(WIDTH), .DW(DW)) u_ptmr_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq)
    );

    always #2 clk = ~clk;

    // reference model
    longint m_per = 0, m_cnt = 0, m_pend = 0;
    bit     m_pv = 0, m_irq = 0;
    longint m_rd = 0;
    bit     m_rd_pending = 0;
    string  rd_tag = "R11";
    string  irq_tag = "R4";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_per = 0; m_cnt = 0; m_pend = 0; m_pv = 0; m_irq = 0;
            m_rd_pending = 0;
        end else begin
            longint o_per, o_cnt, v;
            bit ex;
            o_per = m_per; o_cnt = m_cnt;
            if (rd_en) begin
                case (addr)
                    3'd0: m_rd = o_per;
                    3'd1: m_rd = o_cnt;
                    3'd2: m_rd = m_irq;
                    3'd3: m_rd = MAXP;
                    default: m_rd = 0;
                endcase
                m_rd_pending = 1;
            end
            ex = tick_en && (o_per != 0) && (o_cnt == 0);
            if (wr_en && addr == 3'd2 && wr_data[0]) m_irq = 0;
            if (ex) m_irq = 1;
            if (ex) begin
                if (m_pv) begin m_per = m_pend; m_pv = 0; end
                m_cnt = m_per - 1;
            end else if (tick_en && o_per != 0) begin
                m_cnt = o_cnt - 1;
            end
            if (wr_en && addr == 3'd0) begin
                v = (longint'(wr_data) > MAXP) ? MAXP : longint'(wr_data);
                if (v == 0) begin
                    m_per = 0; m_cnt = 0; m_pend = 0; m_pv = 0;
                end else if (o_per == 0) begin
                    m_per = v; m_cnt = v - 1; m_pv = 0;
                end else begin
                    m_pend = v; m_pv = 1;
                end
            end
        end
    end

    // compare every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                failures++;
                $display("FAIL %s irq: actual=%0b expected=%0b at %0t", irq_tag, irq, m_irq, $time);
            end
            if (m_rd_pending) begin
                m_rd_pending = 0;
                checks++;
                if (longint'(rd_data) !== m_rd) begin
                    failures++;
                    $display("FAIL %s rd_data: actual=%0d expected=%0d at %0t", rd_tag, rd_data, m_rd, $time);
                end
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        rd_en = 1; addr = a; rd_tag = tag;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic expect_val(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        // R1 reset state
        rd(3'd0, "R1");
        rd(3'd1, "R1");
        rd(3'd2, "R1");
        expect_val("R1 irq after reset", irq, 0);
        // R10 / R11 constant and unmapped
        rd(3'd3, "R10");
        rd(3'd5, "R11");
        rd(3'd7, "R11");
        // R7 start from stopped, R2 countdown
        tick_en = 0;
        wr(3'd0, 5);
        rd(3'd0, "R7");
        rd(3'd1, "R7");
        tick_en = 1;
        for (int i = 0; i < 12; i++) rd(3'd1, "R2");
        tick_en = 0;
        // R3 sparse ticks
        for (int i = 0; i < 6; i++) begin
            rd(3'd1, "R3");
            tick_en = (i % 3 == 0);
        end
        tick_en = 0;
        cyc(2);
        // R5 clear bit0=0 ignored, then real clear
        irq_tag = "R5";
        expect_val("R5 irq latched before clear", irq, 1);
        wr(3'd2, 32'hFFFF_FFFE);
        rd(3'd2, "R5");
        wr(3'd2, 1);
        rd(3'd2, "R5");
        // R5 clear coinciding with expiry (period 1, tick high)
        wr(3'd0, 0);
        wr(3'd0, 1);
        tick_en = 1;
        cyc(2);
        wr(3'd2, 1);
        expect_val("R5 set beats clear", irq, 1);
        wr(3'd2, 1);
        tick_en = 0;
        wr(3'd2, 1);
        expect_val("R5 clear without expiry", irq, 0);
        // R8 deferred reload
        irq_tag = "R4";
        wr(3'd0, 0);
        wr(3'd0, 4);
        tick_en = 1;
        cyc(2);
        wr(3'd0, 7);
        rd(3'd0, "R8");
        rd(3'd1, "R8");
        for (int i = 0; i < 10; i++) rd(3'd0, "R8");
        for (int i = 0; i < 8; i++) rd(3'd1, "R8");
        // R6 stop
        irq_tag = "R6";
        tick_en = 0;
        wr(3'd2, 1);
        tick_en = 1;
        wr(3'd0, 0);
        rd(3'd0, "R6");
        rd(3'd1, "R6");
        cyc(20);
        expect_val("R6 no irq while stopped", irq, 0);
        // R9 clamp
        irq_tag = "R9";
        tick_en = 0;
        wr(3'd0, 70000);
        rd(3'd0, "R9");
        rd(3'd1, "R9");
        wr(3'd0, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, "R9");
        wr(3'd0, 0);
        wr(3'd0, 65536);
        rd(3'd0, "R9");
        tick_en = 1;
        cyc(5);
        rd(3'd1, "R9");
        tick_en = 0;
        cyc(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule